// File: doc/BRIEF.md
# Operand Stack Save/Restore Sequencer

This unit copies a small register-file operand stack, together with its stack pointer, out to a fixed-layout state vector in word memory, and copies it back again. It sits beside a control-transfer engine. A save command carries the vector's base address and a destination link. A restore command carries only the base address, and the unit returns the destination link and source link it finds in the vector, ready for the next transfer.

The vector holds the stack entries from word 0 upward. The three control words sit at fixed offsets above the stack area: the packed pointer word at `base+DEPTH`, the destination link at `base+DEPTH+1` and the source link at `base+DEPTH+2`. Every copy takes two entries past the top of stack, so the transfer engine can find its link arguments just above the top. When the stack is full, the last two entry words fall on the same addresses as the pointer word and the destination link. For that reason the control words are always written last.

The packed pointer word also carries a break byte in its upper half. On restore, a nonzero break byte is latched into a break register and raises a pending flag. Acting on the break is left to the surrounding datapath.

Top module: `ssr_unit`

## Requirements
- R1: A save whose current stack pointer is greater than DEPTH (that is, DEPTH+1 or more) finishes with `done` and `err` both high. It makes no memory write and leaves the stack pointer unchanged.
- R2: A valid save copies stack entries 1 through SP+2 into words `base+0` through `base+SP+1`. It does one write per cycle, in ascending address order, and uses the memory port for only one access at a time.
- R3: After the entry writes, a save writes `base+DEPTH` with the stack pointer in bits 7..0 and zero in bits 15..8, then writes `base+DEPTH+1` with the destination link. These two are the last writes, so they take precedence over entry words at the same addresses.
- R4: A valid save loads 0 into the stack pointer and presents `end_addr = base+DEPTH+2` when `done` is high.
- R5: A restore reads the source link from `base+DEPTH+2` and the destination link from `base+DEPTH+1`, and presents both on `slink_o` and `dlink_o` when `done` is high.
- R6: In word `base+DEPTH`, bits 7..0 are the saved stack pointer and bits 15..8 are the break byte. A restore writes stack entries 1 through SP+2 from words `base+0` through `base+SP+1`, then sets the stack pointer to the saved value.
- R7: A restore whose break byte is nonzero loads that byte into `brk_instr` and sets `brk_pending`. A zero break byte leaves both unchanged.
- R8: A restore whose saved stack pointer is greater than DEPTH finishes with `err` high. It makes no stack write and changes neither the stack pointer nor the break state.
- R9: `done` is a single-cycle pulse, and `err` is high only in a `done` cycle.
- R10: After reset, `busy`, `done`, `err`, `brk_pending` and `brk_instr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a command; sampled only while idle |
| cmd_restore | input | 1 | 1 = restore, 0 = save |
| cmd_base | input | ADDR_W | State vector base address |
| cmd_dlink | input | WORD_W | Destination link to store (save only) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Stack pointer out of range; valid with done |
| dlink_o | output | WORD_W | Destination link |
| slink_o | output | WORD_W | Source link read by restore |
| end_addr | output | ADDR_W | base+DEPTH+2 after a save |
| mem_addr | output | ADDR_W | Word memory address |
| mem_rd_en | output | 1 | Memory read; data returns the next cycle |
| mem_wr_en | output | 1 | Memory write |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, one cycle after mem_rd_en |
| stk_addr | output | $clog2(DEPTH+3) | Stack register-file index |
| stk_we | output | 1 | Stack entry write |
| stk_wdata | output | WORD_W | Stack entry write data |
| stk_rdata | input | WORD_W | Stack entry at stk_addr, combinational |
| cur_sp | input | 8 | Current stack pointer |
| sp_we | output | 1 | Load the stack pointer |
| sp_wdata | output | 8 | New stack pointer value |
| brk_instr | output | 8 | Latched break byte |
| brk_pending | output | 1 | A break byte has been latched |

## Verification
The bench builds the unit with the default DEPTH of 14, 16-bit words and 16-bit addresses. At this depth a full stack (SP = 14) and the first illegal pointer (15) can both be reached with a few writes, so the bench can check the full-stack save where the pointer word and destination link overwrite the last two entry words. On the restore side it covers a zero pointer, a pointer above DEPTH with a nonzero break byte, and a save-then-restore round trip.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Sequencer phases
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SV_STK,   // save: copy one stack entry per cycle
    PH_SV_SP,    // save: write packed pointer word
    PH_SV_DL,    // save: write destination link
    PH_RS_SL,    // restore: read source link
    PH_RS_DL,    // restore: read destination link, capture source link
    PH_RS_SP,    // restore: read pointer word, capture destination link
    PH_RS_CAP,   // restore: unpack pointer word
    PH_LD_RD,    // restore: read one vector word
    PH_LD_WR,    // restore: write it to the stack
    PH_RS_FIN    // restore: reload stack pointer
  } ssr_phase_e;

  // Packed pointer word layout: pointer low, break byte above it
  localparam int unsigned PTR_FIELD_W = 8;
  localparam int unsigned BRK_FIELD_W = 8;
  localparam int unsigned BRK_LSB     = PTR_FIELD_W;

endpackage

// File: rtl/ssr_addr.sv
module ssr_addr
  import ssr_pkg::*;
#(
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  ssr_phase_e        phase,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] tail_addr
);

  // Word holding stack entry idx+1
  function automatic logic [ADDR_W-1:0] entry_word(input logic [ADDR_W-1:0] b,
                                                   input logic [IDX_W-1:0] i);
    return b + ADDR_W'(i);
  endfunction

  // Control word k above the stack area (0 pointer, 1 dest, 2 source)
  function automatic logic [ADDR_W-1:0] ctrl_word(input logic [ADDR_W-1:0] b,
                                                  input int unsigned k);
    return b + ADDR_W'(DEPTH) + ADDR_W'(k);
  endfunction

  always_comb begin
    case (phase)
      PH_SV_STK, PH_LD_RD: addr = entry_word(base, idx);
      PH_SV_SP,  PH_RS_SP: addr = ctrl_word(base, 0);
      PH_SV_DL,  PH_RS_DL: addr = ctrl_word(base, 1);
      PH_RS_SL:            addr = ctrl_word(base, 2);
      default:             addr = base;
    endcase
  end

  assign tail_addr = ctrl_word(base, 2);

endmodule

// File: rtl/ssr_brk.sv
module ssr_brk
  import ssr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_en,
  input  logic [BRK_FIELD_W-1:0] cap_byte,
  output logic [BRK_FIELD_W-1:0] brk_instr,
  output logic                   brk_pending
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_instr   <= '0;
      brk_pending <= 1'b0;
    end else if (cap_en) begin
      brk_instr   <= cap_byte;
      brk_pending <= 1'b1;
    end
  end

  // R7: a captured byte shows up as pending the following cycle
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (brk_pending && brk_instr == $past(cap_byte)));

  // R7: without a capture the break register holds its value
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(brk_instr));

  // R7: a pending break stays pending
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pending |=> brk_pending);

endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
  import ssr_pkg::*;
#(
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned STK_AW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_restore,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic [WORD_W-1:0]      cmd_dlink,
  input  logic [PTR_FIELD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0]      mem_rdata,
  input  logic [WORD_W-1:0]      stk_rdata,
  input  logic [ADDR_W-1:0]      tail_addr,
  input  logic [ADDR_W-1:0]      mem_addr,
  output ssr_phase_e             phase,
  output logic [ADDR_W-1:0]      base_q,
  output logic [PTR_FIELD_W-1:0] idx_q,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic [WORD_W-1:0]      mem_wdata,
  output logic                   stk_we,
  output logic [STK_AW-1:0]      stk_addr,
  output logic [WORD_W-1:0]      stk_wdata,
  output logic                   sp_we,
  output logic [PTR_FIELD_W-1:0] sp_wdata,
  output logic                   done,
  output logic                   err,
  output logic                   busy,
  output logic [WORD_W-1:0]      dlink_q,
  output logic [WORD_W-1:0]      slink_q,
  output logic [ADDR_W-1:0]      end_q,
  output logic                   cap_en,
  output logic [BRK_FIELD_W-1:0] cap_byte
);

  localparam int unsigned SPW = PTR_FIELD_W;
  localparam logic [SPW-1:0] SP_LIMIT = SPW'(DEPTH);

  ssr_phase_e     ph_q, ph_d;
  logic [SPW-1:0] sp_q;

  // Named internal events
  logic           accept_save, accept_rest;
  logic           sp_bad_save, sp_bad_rest;
  logic           last_entry;
  logic [SPW-1:0] rd_ptr;
  logic [BRK_FIELD_W-1:0] rd_brk;

  function automatic logic is_last(input logic [SPW-1:0] i, input logic [SPW-1:0] sp);
    return ({1'b0, i} == ({1'b0, sp} + 1'b1));
  endfunction

  function automatic logic [STK_AW-1:0] entry_slot(input logic [SPW-1:0] i);
    return STK_AW'({1'b0, i} + 1'b1);
  endfunction

  assign accept_save = (ph_q == PH_IDLE) && cmd_valid && !cmd_restore;
  assign accept_rest = (ph_q == PH_IDLE) && cmd_valid &&  cmd_restore;
  assign sp_bad_save = cur_sp > SP_LIMIT;
  assign rd_ptr      = mem_rdata[SPW-1:0];
  assign rd_brk      = mem_rdata[BRK_LSB +: BRK_FIELD_W];
  assign sp_bad_rest = rd_ptr > SP_LIMIT;
  assign last_entry  = is_last(idx_q, sp_q);

  assign phase = ph_q;
  assign busy  = (ph_q != PH_IDLE);

  // Next phase
  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:   if (accept_save && !sp_bad_save) ph_d = PH_SV_STK;
                 else if (accept_rest)            ph_d = PH_RS_SL;
      PH_SV_STK: if (last_entry) ph_d = PH_SV_SP;
      PH_SV_SP:  ph_d = PH_SV_DL;
      PH_SV_DL:  ph_d = PH_IDLE;
      PH_RS_SL:  ph_d = PH_RS_DL;
      PH_RS_DL:  ph_d = PH_RS_SP;
      PH_RS_SP:  ph_d = PH_RS_CAP;
      PH_RS_CAP: ph_d = sp_bad_rest ? PH_IDLE : PH_LD_RD;
      PH_LD_RD:  ph_d = PH_LD_WR;
      PH_LD_WR:  ph_d = last_entry ? PH_RS_FIN : PH_LD_RD;
      PH_RS_FIN: ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  // Port drive
  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_wdata = '0;
    stk_we    = 1'b0;
    stk_addr  = entry_slot(idx_q);
    stk_wdata = mem_rdata;
    sp_we     = 1'b0;
    sp_wdata  = '0;
    case (ph_q)
      PH_SV_STK: begin
        mem_wr_en = 1'b1;
        mem_wdata = stk_rdata;
      end
      PH_SV_SP: begin
        mem_wr_en = 1'b1;
        mem_wdata[SPW-1:0] = sp_q;
      end
      PH_SV_DL: begin
        mem_wr_en = 1'b1;
        mem_wdata = dlink_q;
        sp_we     = 1'b1;
      end
      PH_RS_SL, PH_RS_DL, PH_RS_SP, PH_LD_RD: mem_rd_en = 1'b1;
      PH_LD_WR:  stk_we = 1'b1;
      PH_RS_FIN: begin
        sp_we    = 1'b1;
        sp_wdata = sp_q;
      end
      default: ;
    endcase
  end

  assign cap_en   = (ph_q == PH_RS_CAP) && !sp_bad_rest && (rd_brk != '0);
  assign cap_byte = rd_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      sp_q    <= '0;
      dlink_q <= '0;
      slink_q <= '0;
      end_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      ph_q <= ph_d;
      done <= 1'b0;
      err  <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (cmd_valid) begin
            base_q <= cmd_base;
            idx_q  <= '0;
          end
          if (accept_save) begin
            dlink_q <= cmd_dlink;
            sp_q    <= cur_sp;
            if (sp_bad_save) begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end
        end
        PH_SV_STK: if (!last_entry) idx_q <= idx_q + 1'b1;
        PH_SV_DL: begin
          end_q <= tail_addr;
          done  <= 1'b1;
        end
        PH_RS_DL: slink_q <= mem_rdata;
        PH_RS_SP: dlink_q <= mem_rdata;
        PH_RS_CAP: begin
          sp_q  <= rd_ptr;
          idx_q <= '0;
          if (sp_bad_rest) begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        PH_LD_WR: if (!last_entry) idx_q <= idx_q + 1'b1;
        PH_RS_FIN: done <= 1'b1;
        default: ;
      endcase
    end
  end

  // R1: an out-of-range save ends at once with an error and no writes
  p_guard_save_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_save && sp_bad_save) |=> (done && err && !mem_wr_en && !sp_we));

  // R2: the memory port never reads and writes together
  p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R3: the destination link write is right after the pointer word write
  p_ctrl_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SV_SP) |=> (mem_wr_en && mem_addr == $past(mem_addr) + 1'b1));

  // R6: stack writes stay within entries 1..DEPTH+2
  p_stk_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (stk_addr >= STK_AW'(1) && stk_addr <= STK_AW'(DEPTH + 2)));

  // R8: a bad restored pointer ends the command without stack writes
  p_bad_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RS_CAP && sp_bad_rest) |=> (done && err && !stk_we && !sp_we));

  // R9: done is one cycle wide and err only accompanies it
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

// File: rtl/ssr_unit.sv
module ssr_unit
  import ssr_pkg::*;
#(
  parameter int unsigned DEPTH  = 14,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned STK_AW = $clog2(DEPTH + 3)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_restore,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic [WORD_W-1:0]      cmd_dlink,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [WORD_W-1:0]      dlink_o,
  output logic [WORD_W-1:0]      slink_o,
  output logic [ADDR_W-1:0]      end_addr,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic [WORD_W-1:0]      mem_wdata,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic [STK_AW-1:0]      stk_addr,
  output logic                   stk_we,
  output logic [WORD_W-1:0]      stk_wdata,
  input  logic [WORD_W-1:0]      stk_rdata,
  input  logic [7:0]             cur_sp,
  output logic                   sp_we,
  output logic [7:0]             sp_wdata,
  output logic [7:0]             brk_instr,
  output logic                   brk_pending
);

  ssr_phase_e             phase;
  logic [ADDR_W-1:0]      base_q;
  logic [PTR_FIELD_W-1:0] idx_q;
  logic [ADDR_W-1:0]      tail_addr;
  logic                   cap_en;
  logic [BRK_FIELD_W-1:0] cap_byte;

  ssr_addr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(PTR_FIELD_W)) u_addr (
    .phase     (phase),
    .base      (base_q),
    .idx       (idx_q),
    .addr      (mem_addr),
    .tail_addr (tail_addr)
  );

  ssr_seq #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .STK_AW(STK_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_restore (cmd_restore),
    .cmd_base    (cmd_base),
    .cmd_dlink   (cmd_dlink),
    .cur_sp      (cur_sp),
    .mem_rdata   (mem_rdata),
    .stk_rdata   (stk_rdata),
    .tail_addr   (tail_addr),
    .mem_addr    (mem_addr),
    .phase       (phase),
    .base_q      (base_q),
    .idx_q       (idx_q),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wdata   (mem_wdata),
    .stk_we      (stk_we),
    .stk_addr    (stk_addr),
    .stk_wdata   (stk_wdata),
    .sp_we       (sp_we),
    .sp_wdata    (sp_wdata),
    .done        (done),
    .err         (err),
    .busy        (busy),
    .dlink_q     (dlink_o),
    .slink_q     (slink_o),
    .end_q       (end_addr),
    .cap_en      (cap_en),
    .cap_byte    (cap_byte)
  );

  ssr_brk u_brk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cap_byte    (cap_byte),
    .brk_instr   (brk_instr),
    .brk_pending (brk_pending)
  );

endmodule

// File: tb/test_ssr_unit.sv
module test_ssr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 14;
  localparam int AW = 16;
  localparam int WW = 16;
  localparam int SAW = $clog2(DEPTH + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_restore = 1'b0;
  logic [AW-1:0] cmd_base = '0;
  logic [WW-1:0] cmd_dlink = '0;
  logic busy, done, err, brk_pending;
  logic [WW-1:0] dlink_o, slink_o, mem_wdata, stk_wdata, stk_rdata;
  logic [WW-1:0] mem_rdata = '0;
  logic [AW-1:0] end_addr, mem_addr;
  logic mem_rd_en, mem_wr_en, stk_we, sp_we;
  logic [SAW-1:0] stk_addr;
  logic [7:0] sp_wdata, brk_instr;
  logic [7:0] sp_reg = '0;

  // Bench-side backdoor ports into the models
  logic tb_mw = 1'b0, tb_sw = 1'b0, tb_spw = 1'b0;
  logic [7:0] tb_ma = '0;
  logic [SAW-1:0] tb_sa = '0;
  logic [WW-1:0] tb_d = '0;
  logic [7:0] tb_spd = '0;

  logic [WW-1:0] wmem [0:255];
  logic [WW-1:0] stk  [0:(2**SAW)-1];
  logic [AW-1:0] wr_log [0:255];
  int wr_cnt = 0;
  int stk_wcnt = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit got_err;
  logic [AW-1:0] got_end;
  logic [WW-1:0] got_dl, got_sl;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssr_unit #(.DEPTH(DEPTH), .WORD_W(WW), .ADDR_W(AW)) i_ssr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_restore(cmd_restore),
    .cmd_base(cmd_base), .cmd_dlink(cmd_dlink), .busy(busy), .done(done), .err(err),
    .dlink_o(dlink_o), .slink_o(slink_o), .end_addr(end_addr), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stk_addr(stk_addr), .stk_we(stk_we), .stk_wdata(stk_wdata),
    .stk_rdata(stk_rdata), .cur_sp(sp_reg), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .brk_instr(brk_instr), .brk_pending(brk_pending)
  );

  // Models: word memory (1-cycle read), stack file, stack pointer register
  assign stk_rdata = stk[stk_addr];
  always @(posedge clk) begin
    if (tb_mw) wmem[tb_ma] <= tb_d;
    else if (mem_wr_en) begin
      wmem[mem_addr[7:0]] <= mem_wdata;
      wr_log[wr_cnt[7:0]] <= mem_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd_en) mem_rdata <= wmem[mem_addr[7:0]];
    if (tb_sw) stk[tb_sa] <= tb_d;
    else if (stk_we) begin
      stk[stk_addr] <= stk_wdata;
      stk_wcnt <= stk_wcnt + 1;
    end
    if (tb_spw) sp_reg <= tb_spd;
    else if (sp_we) sp_reg <= sp_wdata;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke_mem(input int a, input logic [WW-1:0] d);
    @(negedge clk); tb_mw = 1'b1; tb_ma = 8'(a); tb_d = d;
    @(negedge clk); tb_mw = 1'b0;
  endtask

  task automatic poke_stk(input int a, input logic [WW-1:0] d);
    @(negedge clk); tb_sw = 1'b1; tb_sa = SAW'(a); tb_d = d;
    @(negedge clk); tb_sw = 1'b0;
  endtask

  task automatic set_sp(input int v);
    @(negedge clk); tb_spw = 1'b1; tb_spd = 8'(v);
    @(negedge clk); tb_spw = 1'b0;
  endtask

  task automatic fill_mem(input int lo, input int hi, input logic [WW-1:0] d);
    for (int a = lo; a <= hi; a++) poke_mem(a, d);
  endtask

  task automatic fill_stk(input logic [WW-1:0] seed);
    for (int a = 0; a < 2**SAW; a++) poke_stk(a, seed + WW'(a));
  endtask

  // Issue a command and wait for its done pulse; R9 checked on the way out
  task automatic run_cmd(input bit rest, input int base, input logic [WW-1:0] dl);
    bit seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_restore = rest; cmd_base = AW'(base); cmd_dlink = dl;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R9", "done seen", 32'(seen), 32'd1);
    got_err = err; got_end = end_addr; got_dl = dlink_o; got_sl = slink_o;
    @(negedge clk);
    chk("R9", "done one cycle", 32'(done), 32'd0);
    chk("R9", "err low off done", 32'(err), 32'd0);
  endtask

  task automatic t_reset;
    chk("R10", "busy", 32'(busy), 32'd0);
    chk("R10", "done", 32'(done), 32'd0);
    chk("R10", "err", 32'(err), 32'd0);
    chk("R10", "brk_pending", 32'(brk_pending), 32'd0);
    chk("R10", "brk_instr", 32'(brk_instr), 32'd0);
  endtask

  task automatic t_save_small;
    int w0 = wr_cnt;
    fill_stk(16'h0A00);
    set_sp(3);
    run_cmd(1'b0, 'h20, 16'hABCD);
    chk("R1", "no err", 32'(got_err), 32'd0);
    for (int k = 0; k < 5; k++) chk("R2", "entry word", 32'(wmem['h20 + k]), 32'(16'h0A00 + k + 1));
    chk("R2", "word past SP+1 untouched", 32'(wmem['h25]), 32'h0000DEAD);
    chk("R2", "write count", 32'(wr_cnt - w0), 32'd7);
    for (int k = 0; k < 5; k++) chk("R2", "ascending order", 32'(wr_log[w0 + k]), 32'('h20 + k));
    chk("R3", "pointer word", 32'(wmem['h20 + DEPTH]), 32'h0003);
    chk("R3", "dest word", 32'(wmem['h20 + DEPTH + 1]), 32'hABCD);
    chk("R3", "pointer before dest", 32'(wr_log[w0 + 5]), 32'('h20 + DEPTH));
    chk("R3", "dest last", 32'(wr_log[w0 + 6]), 32'('h20 + DEPTH + 1));
    chk("R4", "sp cleared", 32'(sp_reg), 32'd0);
    chk("R4", "end addr", 32'(got_end), 32'('h20 + DEPTH + 2));
  endtask

  task automatic t_save_full;
    int w0 = wr_cnt;
    fill_stk(16'h0B00);
    set_sp(DEPTH);
    run_cmd(1'b0, 'h40, 16'h1357);
    chk("R1", "full stack no err", 32'(got_err), 32'd0);
    chk("R2", "write count full", 32'(wr_cnt - w0), 32'(DEPTH + 4));
    chk("R2", "last plain entry", 32'(wmem['h40 + DEPTH - 1]), 32'(16'h0B00 + DEPTH));
    chk("R3", "pointer overrides entry", 32'(wmem['h40 + DEPTH]), 32'(DEPTH));
    chk("R3", "dest overrides entry", 32'(wmem['h40 + DEPTH + 1]), 32'h1357);
    chk("R4", "sp cleared full", 32'(sp_reg), 32'd0);
  endtask

  task automatic t_save_bad;
    int w0 = wr_cnt;
    set_sp(DEPTH + 1);
    run_cmd(1'b0, 'h30, 16'h2468);
    chk("R1", "err raised", 32'(got_err), 32'd1);
    chk("R1", "no writes", 32'(wr_cnt - w0), 32'd0);
    chk("R1", "word untouched", 32'(wmem['h30]), 32'h0000DEAD);
    chk("R1", "sp unchanged", 32'(sp_reg), 32'(DEPTH + 1));
  endtask

  task automatic t_restore_plain;
    for (int k = 0; k < 5; k++) poke_mem('h60 + k, 16'h1000 + WW'(k));
    poke_mem('h60 + DEPTH, 16'h0003);
    poke_mem('h60 + DEPTH + 1, 16'hD1D1);
    poke_mem('h60 + DEPTH + 2, 16'h5151);
    for (int a = 0; a < 2**SAW; a++) poke_stk(a, 16'h0000);
    run_cmd(1'b1, 'h60, 16'h0000);
    chk("R5", "no err", 32'(got_err), 32'd0);
    chk("R5", "dest link", 32'(got_dl), 32'hD1D1);
    chk("R5", "source link", 32'(got_sl), 32'h5151);
    for (int k = 0; k < 5; k++) chk("R6", "entry reloaded", 32'(stk[k + 1]), 32'(16'h1000 + k));
    chk("R6", "entry past SP+2 untouched", 32'(stk[6]), 32'd0);
    chk("R6", "entry 0 untouched", 32'(stk[0]), 32'd0);
    chk("R6", "sp restored", 32'(sp_reg), 32'd3);
    chk("R7", "no break", 32'(brk_pending), 32'd0);
  endtask

  task automatic t_restore_break;
    poke_mem('h80, 16'h2222);
    poke_mem('h81, 16'h3333);
    poke_mem('h80 + DEPTH, 16'h5A00);
    run_cmd(1'b1, 'h80, 16'h0000);
    chk("R6", "sp zero restored", 32'(sp_reg), 32'd0);
    chk("R6", "entry 1", 32'(stk[1]), 32'h2222);
    chk("R6", "entry 2", 32'(stk[2]), 32'h3333);
    chk("R7", "break byte", 32'(brk_instr), 32'h5A);
    chk("R7", "pending set", 32'(brk_pending), 32'd1);
    run_cmd(1'b1, 'h60, 16'h0000);
    chk("R7", "zero byte keeps break", 32'(brk_instr), 32'h5A);
    chk("R7", "zero byte keeps pending", 32'(brk_pending), 32'd1);
  endtask

  task automatic t_restore_bad;
    int s0 = stk_wcnt;
    poke_mem('hA0 + DEPTH, 16'h3314);
    run_cmd(1'b1, 'hA0, 16'h0000);
    chk("R8", "err raised", 32'(got_err), 32'd1);
    chk("R8", "no stack writes", 32'(stk_wcnt - s0), 32'd0);
    chk("R8", "sp unchanged", 32'(sp_reg), 32'd3);
    chk("R8", "break unchanged", 32'(brk_instr), 32'h5A);
  endtask

  task automatic t_roundtrip;
    fill_stk(16'h0C00);
    set_sp(6);
    poke_mem('hC0 + DEPTH + 2, 16'h8888);
    run_cmd(1'b0, 'hC0, 16'h7777);
    for (int a = 0; a < 2**SAW; a++) poke_stk(a, 16'hFFFF);
    set_sp(9);
    run_cmd(1'b1, 'hC0, 16'h0000);
    chk("R6", "roundtrip sp", 32'(sp_reg), 32'd6);
    for (int k = 1; k <= 8; k++) chk("R6", "roundtrip entry", 32'(stk[k]), 32'(16'h0C00 + k));
    chk("R6", "roundtrip entry 9 untouched", 32'(stk[9]), 32'h0000FFFF);
    chk("R5", "roundtrip dest", 32'(got_dl), 32'h7777);
    chk("R5", "roundtrip source", 32'(got_sl), 32'h8888);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fill_mem(0, 255, 16'hDEAD);
    t_save_small();
    t_save_full();
    t_save_bad();
    t_restore_plain();
    t_restore_break();
    t_restore_bad();
    t_roundtrip();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule